// File: doc/BRIEF.md
# Scrambled NRZI Serial Transmitter

This block turns a stream of parallel words into one serial line. A word arrives with a one-cycle load strobe. The block then sends that word one bit per clock, least significant bit first. It runs on a bit clock that is exactly ten times the word rate, so a new strobe comes every ten bit clocks.

Each serial bit goes through two stages. The first is a self-synchronizing scrambler that divides the stream modulo 2 by x^9+x^4+1, which breaks up long runs for the receiver's clock recovery. The second is an x+1 stage that turns the scrambled NRZ stream into NRZI, so the receiver does not depend on line polarity. The result leaves the block as a true output and a complementary output.

A lock input, normally driven by a PLL lock indicator, gates the pair. While lock is low the pair holds a fixed idle level. When lock returns, the output comes back only at the next word boundary, so the line never carries part of a word.

Top module: `sertx_top`

## Requirements
- R1: Each word sampled with `load` high is sent once over the next ten bit clocks, bit 0 (`word_in[0]`) first and bit 9 last. A receiver that undoes the NRZI stage and the scrambler recovers the word unchanged.
- R2: The scrambled sequence obeys s[n] = b[n] XOR s[n-4] XOR s[n-9], where b is the serial data bit.
- R3: The line sequence obeys y[n] = s[n] XOR y[n-1]. The line level toggles exactly when the scrambled bit is 1.
- R4: `ser_n` is always the complement of `ser_p`, in every state.
- R5: If `lock` is low at a clock edge, then after that edge `ser_p` is 1 and `ser_n` is 0.
- R6: After `lock` rises, the pair stays at the idle level (`ser_p`=1, `ser_n`=0) until bit 0 of the next word appears on the line.
- R7: Reset is synchronous and active high. After reset the pair is idle (`ser_p`=1, `ser_n`=0), and the scrambler history and line level are zero. For example, the first word 0x001 after reset, with `lock` high, gives the line sequence 1,1,1,1,0,0,0,0,1,0 (bit 0 first).
- R8: The scrambler history and line level keep running across word boundaries and are never reloaded, including across all-zero and all-one words.
- R9: With `load` sampled at edge k, line bit j of that word is on the pair after edge k+3+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten per word |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures `word_in`, once every ten cycles |
| word_in | input | 10 | Parallel word; bit 0 is sent first |
| lock | input | 1 | Output enable from the lock indicator |
| ser_p | output | 1 | True serial line output |
| ser_n | output | 1 | Complementary serial line output |

## Verification
Two functions can act on the same edge: a word boundary arriving at the output gate, and a change of `lock`. The bench drops `lock` in the same cycle that a load strobe is sampled, and checks that the pair goes idle on the next edge rather than starting the new word. It then raises `lock` in the middle of a word and checks that the pair stays idle until that word has passed and the next bit 0 arrives. After that, the bench decodes the line again on its own (NRZI undone, then descrambled) and checks that the recovered words match the ones it sent.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  parameter int WORD_W      = 10;
  parameter int SCR_TAP_LO  = 4;
  parameter int SCR_TAP_HI  = 9;
  parameter int PIPE_DEPTH  = 3;  // shifter, scrambler, line stage
endpackage

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int W = sertx_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= word_in;
    else           sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];

  // R1: strobes are single-cycle
  p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/sertx_scrambler.sv
module sertx_scrambler #(
  parameter int TAP_LO = sertx_pkg::SCR_TAP_LO,
  parameter int TAP_HI = sertx_pkg::SCR_TAP_HI
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic bit_o
);
  logic [TAP_HI-1:0] hist_q;
  logic              fb;

  assign fb = bit_i ^ hist_q[TAP_LO-1] ^ hist_q[TAP_HI-1];

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[TAP_HI-2:0], fb};
  end

  assign bit_o = hist_q[0];
endmodule

// File: rtl/sertx_nrzi.sv
module sertx_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic line_o
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_q ^ bit_i;
  end

  assign line_o = line_q;

  // R3: a zero holds the level, a one toggles it
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !bit_i |=> $stable(line_o));
  p_flip_r3: assert property (@(posedge clk) disable iff (rst)
    bit_i |=> (line_o != $past(line_o)));
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int W = sertx_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_in,
  input  logic         lock,
  output logic         ser_p,
  output logic         ser_n
);
  localparam int PIPE = sertx_pkg::PIPE_DEPTH;

  logic            sh_bit, scr_bit, line;
  logic [PIPE-1:0] ld_pipe;
  logic            boundary, en_q, en_next;
  logic            ser_p_q, ser_n_q;

  sertx_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .word_in(word_in), .bit_o(sh_bit));

  sertx_scrambler u_scr (
    .clk(clk), .rst(rst), .bit_i(sh_bit), .bit_o(scr_bit));

  sertx_nrzi u_nrzi (
    .clk(clk), .rst(rst), .bit_i(scr_bit), .line_o(line));

  // strobe delayed to match the data path, marks bit 0 at the output gate
  always_ff @(posedge clk) begin
    if (rst) ld_pipe <= '0;
    else     ld_pipe <= {ld_pipe[PIPE-2:0], load};
  end

  assign boundary = ld_pipe[PIPE-1];
  assign en_next  = lock & (en_q | boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ser_p_q <= 1'b1;
      ser_n_q <= 1'b0;
    end else begin
      en_q    <= en_next;
      ser_p_q <= en_next ? line  : 1'b1;
      ser_n_q <= en_next ? ~line : 1'b0;
    end
  end

  assign ser_p = ser_p_q;
  assign ser_n = ser_n_q;

  p_pair_compl_r4: assert property (@(posedge clk) disable iff (rst)
    ser_n != ser_p);
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (ser_p && !ser_n));
  p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !boundary) |=> (ser_p && !ser_n));
endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;
  logic       clk = 1'b0;
  logic       rst, load, lock;
  logic [9:0] word_in;
  logic       ser_p, ser_n;

  int checks = 0;
  int fails  = 0;
  int words_ok = 0;

  always #10 clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst(rst), .load(load), .word_in(word_in),
    .lock(lock), .ser_p(ser_p), .ser_n(ser_n));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- independent receiver ----------------
  logic [9:0] expq [0:63];
  logic [5:0] wp, rp;
  logic [12:0] ldmark;
  int          lock_run;
  logic        yprev, y_b, d_b, x_b;
  logic [8:0]  dh;
  logic [9:0]  rxw;

  always @(posedge clk) begin
    if (rst) begin
      wp <= '0; ldmark <= '0; lock_run <= 0;
    end else begin
      ldmark <= {ldmark[11:0], load};
      if (load) begin
        expq[wp] <= word_in;
        wp <= wp + 6'd1;
      end
      lock_run <= lock ? lock_run + 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      yprev = 1'b0; dh = '0; rxw = '0; rp = '0;
    end else begin
      y_b   = ser_p;
      d_b   = y_b ^ yprev;               // undo R3
      x_b   = d_b ^ dh[3] ^ dh[8];       // undo R2
      dh    = {dh[7:0], d_b};
      yprev = y_b;
      rxw   = {x_b, rxw[9:1]};           // R1 LSB first
      if (ldmark[12]) begin
        if (lock_run >= 35) begin
          chk(rxw == expq[rp], "R1/R8 word recovered", rxw, expq[rp]);
          chk(ser_n == ~ser_p, "R4 complement", ser_n, ~ser_p);
          words_ok++;
        end
        rp = rp + 6'd1;
      end
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (2) begin
      @(negedge clk);
      chk(ser_p == 1'b1 && ser_n == 1'b0, "R7 idle after reset", {ser_p, ser_n}, 2'b10);
    end
  endtask

  task automatic t_single();
    logic [9:0] exp_line = 10'h10F; // 1,1,1,1,0,0,0,0,1,0 bit0 first
    logic [9:0] got = '0;
    @(negedge clk); load = 1'b1; word_in = 10'h001;
    for (int c = 1; c <= 13; c++) begin
      @(negedge clk);
      load = 1'b0;
      if (c >= 4) begin
        got[c-4] = ser_p;
        chk(ser_n == ~ser_p, "R4 complement", ser_n, ~ser_p);
      end
    end
    chk(got == exp_line, "R2/R3/R7/R9 first word line sequence", got, exp_line);
  endtask

  task automatic send(input logic [9:0] w);
    @(negedge clk); load = 1'b1; word_in = w;
    @(negedge clk); load = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_stream();
    logic [9:0] pat [0:11] = '{10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h001, 10'h200,
                               10'h000, 10'h000, 10'h3FF, 10'h123, 10'h0F0, 10'h30C};
    for (int i = 0; i < 12; i++) send(pat[i]);  // R8 across boundaries
  endtask

  task automatic t_lockdrop();
    logic bad = 1'b0;
    send(10'h1A5); send(10'h05A);
    // lock falls in the same cycle the strobe is sampled
    @(negedge clk); load = 1'b1; word_in = 10'h3C3; lock = 1'b0;
    for (int c = 1; c < 30; c++) begin
      @(negedge clk);
      if (!(ser_p == 1'b1 && ser_n == 1'b0)) bad = 1'b1;
      load = (c % 10 == 0); word_in = 10'h2DB ^ 10'(c);
    end
    chk(!bad, "R5 idle while lock low", bad, 0);
  endtask

  task automatic t_rearm();
    logic bad = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c >= 6 && c <= 13 && !(ser_p == 1'b1 && ser_n == 1'b0)) bad = 1'b1;
      load = (c % 10 == 0);
      word_in = (c < 10) ? 10'h3EF : 10'h3F7;
      if (c == 5) lock = 1'b1;
    end
    chk(!bad, "R6 idle until next word boundary", bad, 0);
    for (int i = 0; i < 6; i++) send(10'h0C5 + 10'(i * 37));
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; lock = 1'b1; word_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_stream();
    t_lockdrop();
    t_rearm();
    repeat (16) @(negedge clk);
    chk(words_ok >= 14, "R1 decoded word count", words_ok, 14);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule